// File: doc/BRIEF.md
# Bottleneck Waiting-Cycle Tracker

This block decides, for each thread that is about to run a contended code region (a lock-protected section, a barrier or a slow pipeline stage), whether that region should run on the core that issued it or be shipped to one of the fast cores. Each region carries a numeric bottleneck identifier. A shared associative table keeps one entry per identifier it currently tracks. Each entry holds the number of threads now spinning on that region and a running total of the thread-cycles spent waiting. Every cycle, each entry's total grows by its current number of waiters. A slow periodic halving of all totals lets the selection follow program phases.

When a total rises above a threshold, the entry is promoted. The identifier and a fast-core number, handed out in rotation, are broadcast to a small lookup table kept beside every issuing core. When the total later falls back to the threshold, or the entry is pushed out of the shared table, that mapping is withdrawn. When a core calls into a region, its own lookup table is consulted. A hit produces a remote decision and a request record (identifier, program counter, stack pointer, issuing core) for the chosen fast core's scheduling buffer, which has one slot per issuing core. A miss lets the region run locally.

The event port takes one event per cycle: begin-wait, end-wait, call or return, each tagged with the bottleneck identifier and the issuing core.

Top module: `bneck_wait_tracker`

## Requirements
- R1: A begin-wait event (kind code 0) whose identifier is present raises that entry's waiter count by one, saturating at its maximum. If the identifier is absent, an entry is allocated with one waiter and a zero total.
- R2: On every clock, each occupied entry's waiting total grows by the waiter count held before that clock. The total saturates at the all-ones value of its 32-bit width.
- R3: An end-wait event (kind code 1) lowers a present entry's waiter count by one and never below zero. For an absent identifier it has no effect.
- R4: An entry whose total is strictly greater than THRESH and that is not yet promoted is installed in every core's lookup table. Its fast core is taken from a rotating counter 0,1,…,NUM_LARGE-1. At most one table update happens per clock, and among several candidates the lowest table slot goes first.
- R5: A promoted entry whose total is at or below THRESH is demoted, and its mapping is removed from every lookup table. A demotion takes precedence over a promotion in the same clock.
- R6: Every AGE_PERIOD clocks, the clock's new total of each entry is halved by a right shift. This happens after that clock's growth.
- R7: Allocation takes the lowest free slot. With no free slot, it replaces the occupied slot with the smallest total, the lowest slot winning ties. If that slot was promoted, its mapping is removed in the same clock, ahead of any other update.
- R8: A call event (kind code 2) produces a response one clock later, based on the issuing core's lookup table as it stood before that clock. On a hit, the response is remote with the mapped fast core, and a request record carries the identifier, PC, SP, core and fast core. On a miss, the response is local and no request is issued.
- R9: Return events (kind code 3) and idle cycles change no table state and produce no response.
- R10: After reset all tables are empty, so every call is answered locally, and no response or request is raised while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An event is present this cycle |
| ev_kind | input | 2 | 0 begin-wait, 1 end-wait, 2 call, 3 return |
| ev_bid | input | ID_W | Bottleneck identifier |
| ev_core | input | CORE_W | Issuing small core |
| ev_pc | input | ADDR_W | Target program counter for a call |
| ev_sp | input | ADDR_W | Stack pointer for a call |
| resp_valid | output | 1 | Decision for the call of the previous cycle |
| resp_remote | output | 1 | 1 run on a fast core, 0 run locally |
| resp_large | output | LARGE_W | Fast core chosen when remote |
| req_valid | output | 1 | Request record for a scheduling buffer |
| req_bid | output | ID_W | Identifier in the request |
| req_pc | output | ADDR_W | Program counter in the request |
| req_sp | output | ADDR_W | Stack pointer in the request |
| req_core | output | CORE_W | Issuing core, selects the buffer slot |
| req_large | output | LARGE_W | Fast core whose buffer receives the request |

## Verification
The properties assume one event per cycle, an ev_kind that is always one of the four codes, and an ev_core below NUM_SMALL. They also assume that a call's identifier and core are held only for the cycle in which they are presented. The bench drives each event for exactly one cycle from the falling edge, draws cores only from the configured range, and holds ev_valid low through reset. Its random phase uses more identifiers than table slots, so replacement, eviction of promoted entries and demotion through halving all occur. Throughout, it keeps the waiter counts far below their saturation point.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

   typedef enum logic [1:0] {
      EV_WAIT_BEGIN = 2'd0,
      EV_WAIT_END   = 2'd1,
      EV_CALL       = 2'd2,
      EV_RETURN     = 2'd3
   } ev_kind_t;

   typedef enum logic [1:0] {
      UPD_NONE    = 2'd0,
      UPD_INSTALL = 2'd1,
      UPD_DROP    = 2'd2
   } upd_op_t;

endpackage

// File: rtl/bwt_table.sv
module bwt_table
   import bwt_pkg::*;
#(
   parameter int          ENTRIES    = 32,
   parameter int          ID_W       = 16,
   parameter int          WAIT_W     = 8,
   parameter int          TWC_W      = 32,
   parameter int unsigned THRESH     = 1000,
   parameter int          AGE_PERIOD = 4096,
   parameter int          NUM_LARGE  = 2,
   parameter int          LARGE_W    = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_valid,
   input  ev_kind_t           ev_kind,
   input  logic [ID_W-1:0]    ev_bid,
   output upd_op_t            upd_op,
   output logic [ID_W-1:0]    upd_bid,
   output logic [LARGE_W-1:0] upd_large
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [TWC_W-1:0] THRESH_V = TWC_W'(THRESH);

   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] prom_q;
   logic [ID_W-1:0]    bid_q  [ENTRIES];
   logic [WAIT_W-1:0]  wait_q [ENTRIES];
   logic [TWC_W-1:0]   twc_q  [ENTRIES];
   logic [TWC_W-1:0]   twc_nxt[ENTRIES];
   logic [LARGE_W-1:0] rr_q;
   logic               age_tick;

   // aging variant: a zero period removes the halving logic
   generate
      if (AGE_PERIOD > 0) begin : g_age
         localparam int AGE_W = (AGE_PERIOD > 1) ? $clog2(AGE_PERIOD) : 1;
         logic [AGE_W-1:0] age_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        age_q <= '0;
            else if (age_tick) age_q <= '0;
            else               age_q <= age_q + 1'b1;
         end
         assign age_tick = (age_q == AGE_W'(AGE_PERIOD - 1));
      end else begin : g_no_age
         assign age_tick = 1'b0;
      end
   endgenerate

   // per-entry growth with saturation, then optional halving
   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_grow
         logic [TWC_W:0]   sum;
         logic [TWC_W-1:0] sat;
         assign sum = {1'b0, twc_q[g]} + (TWC_W+1)'(wait_q[g]);
         assign sat = sum[TWC_W] ? {TWC_W{1'b1}} : sum[TWC_W-1:0];
         assign twc_nxt[g] = age_tick ? (sat >> 1) : sat;
      end
   endgenerate

   logic             wait_begin, wait_end;
   logic             hit, free_found, min_set;
   logic [IDX_W-1:0] hit_idx, free_idx, min_idx, victim;
   logic [TWC_W-1:0] min_val;

   assign wait_begin = ev_valid && (ev_kind == EV_WAIT_BEGIN);
   assign wait_end   = ev_valid && (ev_kind == EV_WAIT_END);

   always_comb begin
      hit        = 1'b0;
      hit_idx    = '0;
      free_found = 1'b0;
      free_idx   = '0;
      min_set    = 1'b0;
      min_idx    = '0;
      min_val    = '1;
      for (int i = 0; i < ENTRIES; i++) begin
         if (vld_q[i] && (bid_q[i] == ev_bid) && !hit) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
         if (!vld_q[i] && !free_found) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(i);
         end
         if (vld_q[i] && (!min_set || (twc_q[i] < min_val))) begin
            min_set = 1'b1;
            min_idx = IDX_W'(i);
            min_val = twc_q[i];
         end
      end
   end

   logic alloc, evict_drop;
   assign alloc      = wait_begin && !hit;
   assign victim     = free_found ? free_idx : min_idx;
   assign evict_drop = alloc && !free_found && prom_q[min_idx];

   logic             promo_found, demo_found;
   logic [IDX_W-1:0] promo_idx, demo_idx;

   always_comb begin
      promo_found = 1'b0;
      promo_idx   = '0;
      demo_found  = 1'b0;
      demo_idx    = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!(alloc && (victim == IDX_W'(i))) && vld_q[i]) begin
            if (!prom_q[i] && (twc_q[i] > THRESH_V) && !promo_found) begin
               promo_found = 1'b1;
               promo_idx   = IDX_W'(i);
            end
            if (prom_q[i] && (twc_q[i] <= THRESH_V) && !demo_found) begin
               demo_found = 1'b1;
               demo_idx   = IDX_W'(i);
            end
         end
      end
   end

   logic do_demo, do_promo;

   always_comb begin
      upd_op    = UPD_NONE;
      upd_bid   = '0;
      upd_large = rr_q;
      do_demo   = 1'b0;
      do_promo  = 1'b0;
      if (evict_drop) begin
         upd_op  = UPD_DROP;
         upd_bid = bid_q[min_idx];
      end else if (demo_found) begin
         upd_op  = UPD_DROP;
         upd_bid = bid_q[demo_idx];
         do_demo = 1'b1;
      end else if (promo_found) begin
         upd_op   = UPD_INSTALL;
         upd_bid  = bid_q[promo_idx];
         do_promo = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         prom_q <= '0;
         rr_q   <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            bid_q[i]  <= '0;
            wait_q[i] <= '0;
            twc_q[i]  <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (alloc && (victim == IDX_W'(i))) begin
               vld_q[i]  <= 1'b1;
               prom_q[i] <= 1'b0;
               bid_q[i]  <= ev_bid;
               wait_q[i] <= WAIT_W'(1);
               twc_q[i]  <= '0;
            end else if (vld_q[i]) begin
               twc_q[i] <= twc_nxt[i];
               if (hit && (hit_idx == IDX_W'(i))) begin
                  if (wait_begin && (wait_q[i] != {WAIT_W{1'b1}}))
                     wait_q[i] <= wait_q[i] + 1'b1;
                  else if (wait_end && (wait_q[i] != '0))
                     wait_q[i] <= wait_q[i] - 1'b1;
               end
               if (do_demo && (demo_idx == IDX_W'(i)))   prom_q[i] <= 1'b0;
               if (do_promo && (promo_idx == IDX_W'(i))) prom_q[i] <= 1'b1;
            end
         end
         if (do_promo)
            rr_q <= (rr_q == LARGE_W'(NUM_LARGE - 1)) ? '0 : rr_q + 1'b1;
      end
   end

endmodule

// File: rtl/bwt_index.sv
module bwt_index
   import bwt_pkg::*;
#(
   parameter int DEPTH   = 32,
   parameter int ID_W    = 16,
   parameter int LARGE_W = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  upd_op_t            upd_op,
   input  logic [ID_W-1:0]    upd_bid,
   input  logic [LARGE_W-1:0] upd_large,
   input  logic [ID_W-1:0]    lk_bid,
   output logic               lk_hit,
   output logic [LARGE_W-1:0] lk_large
);

   localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DEPTH-1:0]   v_q;
   logic [ID_W-1:0]    b_q [DEPTH];
   logic [LARGE_W-1:0] l_q [DEPTH];

   logic              upd_present, slot_found;
   logic [SLOT_W-1:0] slot;

   always_comb begin
      lk_hit      = 1'b0;
      lk_large    = '0;
      upd_present = 1'b0;
      slot_found  = 1'b0;
      slot        = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (v_q[i] && (b_q[i] == lk_bid) && !lk_hit) begin
            lk_hit   = 1'b1;
            lk_large = l_q[i];
         end
         if (v_q[i] && (b_q[i] == upd_bid)) upd_present = 1'b1;
         if (!v_q[i] && !slot_found) begin
            slot_found = 1'b1;
            slot       = SLOT_W'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            b_q[i] <= '0;
            l_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if ((upd_op == UPD_DROP) && v_q[i] && (b_q[i] == upd_bid))
               v_q[i] <= 1'b0;
            if ((upd_op == UPD_INSTALL) && !upd_present && slot_found &&
                (slot == SLOT_W'(i))) begin
               v_q[i] <= 1'b1;
               b_q[i] <= upd_bid;
               l_q[i] <= upd_large;
            end
         end
      end
   end

endmodule

// File: rtl/bneck_wait_tracker.sv
module bneck_wait_tracker
   import bwt_pkg::*;
#(
   parameter int          ENTRIES    = 32,
   parameter int          IDX_DEPTH  = 32,
   parameter int          NUM_SMALL  = 4,
   parameter int          NUM_LARGE  = 2,
   parameter int          ID_W       = 16,
   parameter int          ADDR_W     = 32,
   parameter int          WAIT_W     = 8,
   parameter int          TWC_W      = 32,
   parameter int unsigned THRESH     = 1000,
   parameter int          AGE_PERIOD = 4096,
   localparam int         CORE_W     = (NUM_SMALL > 1) ? $clog2(NUM_SMALL) : 1,
   localparam int         LARGE_W    = (NUM_LARGE > 1) ? $clog2(NUM_LARGE) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_valid,
   input  logic [1:0]         ev_kind,
   input  logic [ID_W-1:0]    ev_bid,
   input  logic [CORE_W-1:0]  ev_core,
   input  logic [ADDR_W-1:0]  ev_pc,
   input  logic [ADDR_W-1:0]  ev_sp,
   output logic               resp_valid,
   output logic               resp_remote,
   output logic [LARGE_W-1:0] resp_large,
   output logic               req_valid,
   output logic [ID_W-1:0]    req_bid,
   output logic [ADDR_W-1:0]  req_pc,
   output logic [ADDR_W-1:0]  req_sp,
   output logic [CORE_W-1:0]  req_core,
   output logic [LARGE_W-1:0] req_large
);

   generate
      if (ENTRIES < 2)          $error("ENTRIES must be at least 2");
      if (IDX_DEPTH < ENTRIES)  $error("IDX_DEPTH must cover every table entry");
      if (NUM_SMALL < 1)        $error("NUM_SMALL must be positive");
      if (NUM_LARGE < 1)        $error("NUM_LARGE must be positive");
      if (WAIT_W >= TWC_W)      $error("WAIT_W must be narrower than TWC_W");
      if (AGE_PERIOD < 0)       $error("AGE_PERIOD must not be negative");
   endgenerate

   ev_kind_t           kind;
   upd_op_t            upd_op;
   logic [ID_W-1:0]    upd_bid;
   logic [LARGE_W-1:0] upd_large;

   assign kind = ev_kind_t'(ev_kind);

   bwt_table #(
      .ENTRIES    (ENTRIES),
      .ID_W       (ID_W),
      .WAIT_W     (WAIT_W),
      .TWC_W      (TWC_W),
      .THRESH     (THRESH),
      .AGE_PERIOD (AGE_PERIOD),
      .NUM_LARGE  (NUM_LARGE),
      .LARGE_W    (LARGE_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_valid  (ev_valid),
      .ev_kind   (kind),
      .ev_bid    (ev_bid),
      .upd_op    (upd_op),
      .upd_bid   (upd_bid),
      .upd_large (upd_large)
   );

   logic [NUM_SMALL-1:0] core_hit;
   logic [LARGE_W-1:0]   core_large [NUM_SMALL];

   generate
      for (genvar c = 0; c < NUM_SMALL; c++) begin : g_core
         bwt_index #(
            .DEPTH   (IDX_DEPTH),
            .ID_W    (ID_W),
            .LARGE_W (LARGE_W)
         ) u_index (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_op    (upd_op),
            .upd_bid   (upd_bid),
            .upd_large (upd_large),
            .lk_bid    (ev_bid),
            .lk_hit    (core_hit[c]),
            .lk_large  (core_large[c])
         );
      end
   endgenerate

   logic               sel_hit;
   logic [LARGE_W-1:0] sel_large;
   logic               is_call;

   always_comb begin
      sel_hit   = 1'b0;
      sel_large = '0;
      for (int c = 0; c < NUM_SMALL; c++) begin
         if (ev_core == CORE_W'(c)) begin
            sel_hit   = core_hit[c];
            sel_large = core_large[c];
         end
      end
   end

   assign is_call = ev_valid && (kind == EV_CALL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid  <= 1'b0;
         resp_remote <= 1'b0;
         resp_large  <= '0;
         req_valid   <= 1'b0;
         req_bid     <= '0;
         req_pc      <= '0;
         req_sp      <= '0;
         req_core    <= '0;
         req_large   <= '0;
      end else begin
         resp_valid  <= is_call;
         resp_remote <= is_call && sel_hit;
         resp_large  <= sel_large;
         req_valid   <= is_call && sel_hit;
         if (is_call && sel_hit) begin
            req_bid   <= ev_bid;
            req_pc    <= ev_pc;
            req_sp    <= ev_sp;
            req_core  <= ev_core;
            req_large <= sel_large;
         end
      end
   end

endmodule

// File: rtl/bneck_wait_tracker_chk.sv
module bneck_wait_tracker_chk #(
   parameter int ID_W      = 16,
   parameter int CORE_W    = 2,
   parameter int LARGE_W   = 1,
   parameter int NUM_LARGE = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ev_valid,
   input logic [1:0]         ev_kind,
   input logic [ID_W-1:0]    ev_bid,
   input logic [CORE_W-1:0]  ev_core,
   input logic               resp_valid,
   input logic               resp_remote,
   input logic               req_valid,
   input logic [ID_W-1:0]    req_bid,
   input logic [CORE_W-1:0]  req_core,
   input logic [LARGE_W-1:0] req_large
);

   assert_req_needs_remote_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (resp_valid && resp_remote));

   assert_call_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == 2'd2) |=> resp_valid);

   assert_noncall_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_valid && ev_kind == 2'd2) |=> !resp_valid);

   assert_req_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == 2'd2) |=>
         (!req_valid || (req_bid == $past(ev_bid) && req_core == $past(ev_core))));

   assert_large_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (int'(req_large) < NUM_LARGE));

endmodule

bind bneck_wait_tracker bneck_wait_tracker_chk #(
   .ID_W      (ID_W),
   .CORE_W    (CORE_W),
   .LARGE_W   (LARGE_W),
   .NUM_LARGE (NUM_LARGE)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ev_valid    (ev_valid),
   .ev_kind     (ev_kind),
   .ev_bid      (ev_bid),
   .ev_core     (ev_core),
   .resp_valid  (resp_valid),
   .resp_remote (resp_remote),
   .req_valid   (req_valid),
   .req_bid     (req_bid),
   .req_core    (req_core),
   .req_large   (req_large)
);

// File: tb/test_bneck_wait_tracker.sv
module test_bneck_wait_tracker;

   localparam int ENT   = 8;
   localparam int NS    = 4;
   localparam int NL    = 3;
   localparam int IDW   = 8;
   localparam int AW    = 16;
   localparam int THR   = 40;
   localparam int AP    = 200;
   localparam int CW    = 2;
   localparam int LW    = 2;
   localparam longint TMAX = 64'hFFFF_FFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_valid = 1'b0;
   logic [1:0] ev_kind = '0;
   logic [IDW-1:0] ev_bid = '0;
   logic [CW-1:0] ev_core = '0;
   logic [AW-1:0] ev_pc = '0;
   logic [AW-1:0] ev_sp = '0;
   logic resp_valid, resp_remote, req_valid;
   logic [LW-1:0] resp_large, req_large;
   logic [IDW-1:0] req_bid;
   logic [AW-1:0] req_pc, req_sp;
   logic [CW-1:0] req_core;

   always #5 clk = ~clk;

   bneck_wait_tracker #(
      .ENTRIES(ENT), .IDX_DEPTH(ENT), .NUM_SMALL(NS), .NUM_LARGE(NL),
      .ID_W(IDW), .ADDR_W(AW), .WAIT_W(8), .TWC_W(32),
      .THRESH(THR), .AGE_PERIOD(AP)
   ) i_bneck_wait_tracker (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_bid(ev_bid), .ev_core(ev_core), .ev_pc(ev_pc), .ev_sp(ev_sp),
      .resp_valid(resp_valid), .resp_remote(resp_remote), .resp_large(resp_large),
      .req_valid(req_valid), .req_bid(req_bid), .req_pc(req_pc), .req_sp(req_sp),
      .req_core(req_core), .req_large(req_large)
   );

   int n_checks = 0;
   int n_errors = 0;
   string cur_req = "R10";

   // behavioural reference state
   int     m_vld [ENT];
   int     m_bid [ENT];
   int     m_wt  [ENT];
   int     m_prom[ENT];
   longint m_twc [ENT];
   int     m_rr = 0;
   int     m_age = 0;
   int     m_map [int];

   int e_rv, e_rr, e_rl, e_qv, e_qb, e_qpc, e_qsp, e_qc;

   task automatic chk(string req, string what, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void model(int v, int k, int b, int c, int pc, int sp);
      int hit, fr, mn, vic, pr, dm, alloc, tick;
      e_rv = (v != 0 && k == 2) ? 1 : 0;
      e_rr = (e_rv != 0 && m_map.exists(b)) ? 1 : 0;
      e_rl = e_rr ? m_map[b] : 0;
      e_qv = e_rr; e_qb = b; e_qpc = pc; e_qsp = sp; e_qc = c;
      hit = -1; fr = -1; mn = -1; pr = -1; dm = -1;
      for (int i = 0; i < ENT; i++) begin
         if (m_vld[i] != 0 && m_bid[i] == b && hit < 0) hit = i;
         if (m_vld[i] == 0 && fr < 0) fr = i;
         if (m_vld[i] != 0 && (mn < 0 || m_twc[i] < m_twc[mn])) mn = i;
      end
      alloc = (v != 0 && k == 0 && hit < 0) ? 1 : 0;
      vic = (fr >= 0) ? fr : mn;
      for (int i = 0; i < ENT; i++) begin
         if (!(alloc != 0 && i == vic) && m_vld[i] != 0) begin
            if (m_prom[i] == 0 && m_twc[i] > THR && pr < 0) pr = i;
            if (m_prom[i] != 0 && m_twc[i] <= THR && dm < 0) dm = i;
         end
      end
      if (alloc != 0 && fr < 0 && m_prom[mn] != 0) m_map.delete(m_bid[mn]);
      else if (dm >= 0) begin m_map.delete(m_bid[dm]); m_prom[dm] = 0; end
      else if (pr >= 0) begin
         m_map[m_bid[pr]] = m_rr; m_prom[pr] = 1; m_rr = (m_rr + 1) % NL;
      end
      tick = (m_age == AP - 1) ? 1 : 0;
      for (int i = 0; i < ENT; i++) begin
         if (alloc != 0 && i == vic) begin
            m_vld[i] = 1; m_bid[i] = b; m_wt[i] = 1; m_twc[i] = 0; m_prom[i] = 0;
         end else if (m_vld[i] != 0) begin
            m_twc[i] = m_twc[i] + m_wt[i];
            if (m_twc[i] > TMAX) m_twc[i] = TMAX;
            if (tick != 0) m_twc[i] = m_twc[i] >> 1;
            if (i == hit && v != 0 && k == 0 && m_wt[i] < 255) m_wt[i]++;
            if (i == hit && v != 0 && k == 1 && m_wt[i] > 0) m_wt[i]--;
         end
      end
      m_age = tick ? 0 : m_age + 1;
   endfunction

   task automatic ev(int v, int k, int b, int c);
      int pc, sp;
      pc = (b * 37 + c) & 16'hFFFF;
      sp = (16'h8000 + c * 256 + b) & 16'hFFFF;
      ev_valid = v[0]; ev_kind = k[1:0]; ev_bid = b[IDW-1:0];
      ev_core = c[CW-1:0]; ev_pc = pc[AW-1:0]; ev_sp = sp[AW-1:0];
      model(v, k, b, c, pc, sp);
      @(negedge clk);
      chk(cur_req, "resp_valid", resp_valid, e_rv);
      chk(cur_req, "req_valid", req_valid, e_qv);
      if (e_rv != 0) chk(cur_req, "resp_remote", resp_remote, e_rr);
      if (e_rr != 0) begin
         chk(cur_req, "resp_large", resp_large, e_rl);
         chk(cur_req, "req_bid", req_bid, e_qb);
         chk(cur_req, "req_pc", req_pc, e_qpc);
         chk(cur_req, "req_sp", req_sp, e_qsp);
         chk(cur_req, "req_core", req_core, e_qc);
         chk(cur_req, "req_large", req_large, e_rl);
      end
   endtask

   // probe with calls for n cycles, rotating over cores
   task automatic probe(int b, int n);
      for (int i = 0; i < n; i++) ev(1, 2, b, i % NS);
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < ENT; i++) begin
         m_vld[i] = 0; m_bid[i] = 0; m_wt[i] = 0; m_prom[i] = 0; m_twc[i] = 0;
      end
      // R10: quiet while reset is held
      repeat (3) @(negedge clk);
      chk("R10", "resp_valid in reset", resp_valid, 0);
      chk("R10", "req_valid in reset", req_valid, 0);
      rst_n = 1'b1;
      cur_req = "R10";
      for (int c = 0; c < NS; c++) ev(1, 2, 5, c);
      chk("R10", "local after reset", resp_remote, 0);

      // R1, R2, R4: three waiters on id 5, promotion after the total passes THRESH
      cur_req = "R1";
      ev(1, 0, 5, 0); ev(1, 0, 5, 1); ev(1, 0, 5, 2);
      cur_req = "R2";
      probe(5, 12);
      cur_req = "R4";
      probe(5, 10);
      chk("R4", "id 5 promoted", resp_remote, 1);

      // R3: release waiters, extra end-wait and unknown id
      cur_req = "R3";
      ev(1, 1, 5, 0); ev(1, 1, 5, 1); ev(1, 1, 5, 2); ev(1, 1, 5, 3);
      ev(1, 1, 77, 0);
      probe(5, 4);

      // R4 rotation: two more ids promoted in turn
      cur_req = "R4";
      ev(1, 0, 9, 0); ev(1, 0, 9, 1); ev(1, 0, 11, 2); ev(1, 0, 11, 3);
      for (int i = 0; i < 30; i++) ev(1, 2, (i % 2) ? 9 : 11, i % NS);

      // R6, R5: let aging halve totals until demotion
      cur_req = "R6";
      ev(1, 1, 9, 0); ev(1, 1, 9, 1); ev(1, 1, 11, 2); ev(1, 1, 11, 3);
      probe(5, 150);
      cur_req = "R5";
      for (int i = 0; i < 450; i++) ev(1, 2, (i % 3 == 0) ? 5 : ((i % 3 == 1) ? 9 : 11), i % NS);
      chk("R5", "id 11 demoted", resp_remote, 0);

      // R9: returns and idle cycles
      cur_req = "R9";
      for (int i = 0; i < 20; i++) ev((i % 2), 3, 5, i % NS);
      probe(9, 4);

      // R7: fill table, promote one, then force replacement
      cur_req = "R7";
      for (int b = 20; b < 28; b++) ev(1, 0, b, b % NS);
      ev(1, 0, 27, 0); ev(1, 0, 27, 1);
      probe(27, 25);
      for (int b = 30; b < 40; b++) begin
         ev(1, 0, b, b % NS);
         probe(27, 2);
      end

      // R8 and mixed: random traffic over more ids than slots
      cur_req = "R8";
      for (int i = 0; i < 4000; i++) begin
         int r, k;
         r = $urandom_range(0, 99);
         k = (r < 32) ? 0 : (r < 62) ? 1 : (r < 92) ? 2 : 3;
         ev((r % 11 != 0) ? 1 : 0, k, $urandom_range(0, 11), $urandom_range(0, NS - 1));
      end
      ev(0, 0, 0, 0);
      finish_run();
   end

endmodule